// File: doc/BRIEF.md
# Scanline Display Address Generator

This block steps once per video scanline, on a single-cycle `line_adv` strobe. It keeps the current line number and a packed 16-bit working display address. For each line it produces a registered row address and column address for video memory, a flag saying whether the line is inside the displayed span, and a one-cycle display interrupt pulse.

The working address has two parts. Its upper fourteen bits count down by a programmable step taken from the control word. Its low two bits form a sub-counter that decrements once per line and is reloaded from the start value each time it passes zero. The address can be driven out inverted or unchanged.

All register inputs are sampled at the strobe edge. A write made in the middle of a line therefore takes effect on the next line. Pixel shifting, horizontal timing and the memory access itself are left to other blocks.

Top module: `scanline_addr_gen`

## Requirements
- R1: After reset, `vcount`, `line_valid`, `row_addr`, `col_addr` and `irq_pulse` are zero. The internal line counter and the working address also start at zero.
- R2: On each strobe, `vcount` shows the line just processed, L. The next line is L+1, or 0 when L+1 is greater than or equal to `vtotal`.
- R3: `irq_pulse` is high for exactly the one cycle after a strobe whose line equals `irq_line`, and only when `disp_ctl[15]` is 1.
- R4: `line_valid` is 1 after a strobe whose line L satisfies `vblank_end` <= L <= `vblank_start`. Otherwise it is 0.
- R5: On the line equal to `vblank_start`, the working address is replaced by `disp_start`. The output address for that same line is taken from `disp_start`.
- R6: The output address is the working address XOR 0xFFFC when `disp_ctl[10]` is 0. It is the working address unchanged when `disp_ctl[10]` is 1.
- R7: `row_addr` is output address bits 15..4. `col_addr` is output address bits 6..2 placed at bits 10..6, ORed with `disp_tap[13:0]`.
- R8: On a line with `vblank_end` <= L < `vblank_start` whose working address has low bits 00, the next working address is computed as follows. Take (address AND 0xFFFC), subtract (`disp_ctl` AND 0x03FC), and then set the low bits to `disp_start[1:0]`.
- R9: On such a line whose low bits are not 00, only the low two bits decrement. Bits 15..2 are unchanged.
- R10: In cycles with no strobe, `vcount`, `line_valid`, `row_addr` and `col_addr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_adv | input | 1 | One-cycle line advance strobe |
| vblank_end | input | LINE_W | First displayed line |
| vblank_start | input | LINE_W | Last displayed line and address reload line |
| vtotal | input | LINE_W | Lines per frame |
| irq_line | input | LINE_W | Line that raises the interrupt |
| disp_start | input | 16 | Display start address |
| disp_tap | input | 16 | Column tap; low 14 bits used |
| disp_ctl | input | 16 | Control: bit 15 interrupt enable, bit 10 no-invert, bits 9..2 step |
| vcount | output | LINE_W | Line processed at the last strobe |
| line_valid | output | 1 | Line is in the displayed span |
| row_addr | output | 12 | Video memory row address |
| col_addr | output | 14 | Video memory column address |
| irq_pulse | output | 1 | Display interrupt pulse |

## Verification
The assertions assume three things about the inputs:
- strobes are separated by at least one idle cycle;
- `vtotal` is non-zero;
- `vblank_end` does not exceed `vblank_start`.

Under these conditions the line counter only ever increments or wraps, and stepping never overlaps the reload line. The stimulus keeps every strobe two idle cycles apart and uses a fixed 12-line frame with a span from line 2 to line 8. It sweeps both inversion settings, all four start sub-counter values and three step sizes, so the sub-counter reload and the upper-bit subtraction each occur many times per frame.

// File: rtl/scanline_addr_gen.sv
module scanline_addr_gen #(
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_adv,
  input  logic [LINE_W-1:0] vblank_end,
  input  logic [LINE_W-1:0] vblank_start,
  input  logic [LINE_W-1:0] vtotal,
  input  logic [LINE_W-1:0] irq_line,
  input  logic [15:0]       disp_start,
  input  logic [15:0]       disp_tap,
  input  logic [15:0]       disp_ctl,
  output logic [LINE_W-1:0] vcount,
  output logic              line_valid,
  output logic [11:0]       row_addr,
  output logic [13:0]       col_addr,
  output logic              irq_pulse
);
  localparam logic [15:0] INV_MASK  = 16'hFFFC;
  localparam logic [15:0] STEP_MASK = 16'h03FC;

  logic [LINE_W-1:0] cur_line;
  logic [15:0]       work_addr;

  wire at_load  = cur_line == vblank_start;
  wire in_span  = cur_line >= vblank_end && cur_line <= vblank_start;
  wire stepping = cur_line >= vblank_end && cur_line <  vblank_start;

  wire [15:0] base  = at_load ? disp_start : work_addr;
  wire [15:0] shown = disp_ctl[10] ? base : (base ^ INV_MASK);

  wire [15:0] stepped = (base[1:0] == 2'b00)
    ? (((base & INV_MASK) - (disp_ctl & STEP_MASK)) | {14'b0, disp_start[1:0]})
    : {base[15:2], base[1:0] - 2'd1};

  wire [LINE_W-1:0] line_plus = cur_line + 1'b1;
  wire [LINE_W-1:0] line_next = (line_plus >= vtotal) ? '0 : line_plus;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_line   <= '0;
      work_addr  <= '0;
      vcount     <= '0;
      line_valid <= 1'b0;
      row_addr   <= '0;
      col_addr   <= '0;
      irq_pulse  <= 1'b0;
    end else begin
      irq_pulse <= 1'b0;
      if (line_adv) begin
        vcount     <= cur_line;
        cur_line   <= line_next;
        line_valid <= in_span;
        row_addr   <= shown[15:4];
        col_addr   <= {3'b000, shown[6:2], 6'b000000} | disp_tap[13:0];
        irq_pulse  <= disp_ctl[15] && (cur_line == irq_line);
        if (at_load)       work_addr <= disp_start;
        else if (stepping) work_addr <= stepped;
      end
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (vcount == '0 && !line_valid && !irq_pulse && work_addr == '0));

  assert_line_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_adv |=> (cur_line == '0 || cur_line == $past(cur_line) + 1'b1));

  assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> ($past(line_adv) && $past(disp_ctl[15])));

  assert_irq_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_adv && at_load) |=> work_addr == $past(disp_start));

  assert_subcount_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (line_adv && stepping && work_addr[1:0] != 2'b00) |=>
      (work_addr[15:2] == $past(work_addr[15:2]) &&
       work_addr[1:0] == $past(work_addr[1:0]) - 2'd1));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !line_adv |=> ($stable(vcount) && $stable(line_valid) && $stable(row_addr)));
endmodule

// File: tb/scanline_addr_gen_test.sv
`timescale 1ns/1ps
module scanline_addr_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_adv = 1'b0;
  logic [15:0] vblank_end = 16'd2, vblank_start = 16'd8, vtotal = 16'd12, irq_line = 16'd5;
  logic [15:0] disp_start = 16'h0, disp_tap = 16'h0, disp_ctl = 16'h0;
  logic [15:0] vcount;
  logic line_valid, irq_pulse;
  logic [11:0] row_addr;
  logic [13:0] col_addr;

  int checks = 0;
  int fails = 0;
  logic [15:0] m_line = 16'd0;
  logic [15:0] m_addr = 16'd0;

  always #4 clk = ~clk;

  scanline_addr_gen #(.LINE_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .line_adv(line_adv),
    .vblank_end(vblank_end), .vblank_start(vblank_start), .vtotal(vtotal), .irq_line(irq_line),
    .disp_start(disp_start), .disp_tap(disp_tap), .disp_ctl(disp_ctl),
    .vcount(vcount), .line_valid(line_valid), .row_addr(row_addr), .col_addr(col_addr),
    .irq_pulse(irq_pulse));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_line();
    logic [15:0] L, base, shown, nxt;
    logic [13:0] ecol;
    bit valid, eirq;
    L = m_line;
    base = (L == vblank_start) ? disp_start : m_addr;
    shown = disp_ctl[10] ? base : (base ^ 16'hFFFC);
    valid = (L >= vblank_end) && (L <= vblank_start);
    eirq = disp_ctl[15] && (L == irq_line);
    ecol = {3'b000, shown[6:2], 6'b0} | disp_tap[13:0];
    if (L == vblank_start) m_addr = disp_start;
    else if (L >= vblank_end && L < vblank_start) begin
      if (base[1:0] == 2'b00) nxt = ((base & 16'hFFFC) - (disp_ctl & 16'h03FC)) | {14'b0, disp_start[1:0]};
      else nxt = {base[15:2], base[1:0] - 2'd1};
      m_addr = nxt;
    end
    m_line = (L + 16'd1 >= vtotal) ? 16'd0 : L + 16'd1;

    line_adv = 1'b1;
    @(negedge clk);
    line_adv = 1'b0;
    check(vcount == L, "R2 vcount", vcount, L);
    check(line_valid == valid, "R4 valid", line_valid, valid);
    check(irq_pulse == eirq, "R3 irq", irq_pulse, eirq);
    if (valid) begin
      check(row_addr == shown[15:4], "R5 R6 R7 R8 R9 row", row_addr, shown[15:4]);
      check(col_addr == ecol, "R6 R7 col", col_addr, ecol);
    end
    @(negedge clk);
    check(!irq_pulse, "R3 pulse end", irq_pulse, 0);
    check(vcount == L && line_valid == valid, "R10 hold", vcount, L);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(vcount == 0 && !line_valid && !irq_pulse && row_addr == 0 && col_addr == 0,
          "R1 reset", {vcount, 16'(row_addr)}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int inv = 0; inv < 2; inv++) begin
      for (int s = 0; s < 4; s++) begin
        for (int k = 0; k < 3; k++) begin
          disp_start = 16'hA5F0 | 16'(s);
          disp_tap   = 16'h1234 ^ 16'(k * 16'h0411);
          disp_ctl   = (k == 0) ? 16'h0004 : (k == 1) ? 16'h03FC : 16'h0088;
          if (inv == 1) disp_ctl = disp_ctl | 16'h0400;
          if (s[0]) disp_ctl = disp_ctl | 16'h8000;
          irq_line = 16'(3 + s + k);
          for (int n = 0; n < 12; n++) do_line();
        end
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule